// File: doc/BRIEF.md
# Dual-Loop Phase-Frequency Detector with Lock and Power Sequencing

This block holds the digital back end of two phase-locked loops: a main loop and an auxiliary loop. Each loop takes a one-cycle pulse from its reference divider and one from its feedback divider. It keeps a pair of edge flags and turns them into pump-up and pump-down commands. Configuration bits set the polarity of those commands, force them idle, or choose the 1x/4x current level. Each loop also drives a lock level, a synchronous reset for its two dividers, and an active flag that enables it. The loop leaves its powered state cleanly: it waits for a pump pulse to finish, or it stops at once.

One shared multifunction output is driven by a selector made of two 2-bit mode fields, one per loop. The output can be idle low, show one lock level or both combined, pass a divider pulse through, drive the fast-lock switch, or hold counters in reset. The analog pump, the loop filter and the output pad are outside this block.

Top module: `pfd_dual`

## Requirements
- R1: For each loop, a pulse on `ref_pulse_i` sets a reference flag and a pulse on `fb_pulse_i` sets a feedback flag, both at the next clock edge. With `pol_i`=1, `pump_up_o` shows the reference flag and `pump_dn_o` shows the feedback flag. With `pol_i`=0 the two are swapped.
- R2: When both flags of a loop are set, both clear at the next edge. Any pulse arriving in that cycle is dropped. Up and down are therefore both active for exactly one cycle, which gives a minimum-width overlap.
- R3: While `tri_i` of a loop is 1, both of its pump outputs are 0.
- R4: `lock_o` is 1 when neither flag of the loop is set and 0 while either flag is set. It is 1 whenever the loop is powered down.
- R5: `x4_o` takes the value of `x4_cfg_i` at an edge only if both flags were clear before that edge. Otherwise it keeps its value. It resets to 0.
- R6: `active_o` is 1 after reset. With `pwdn_i`=1 and `tri_i`=1, `active_o` falls at the next edge. With `pwdn_i`=1 and `tri_i`=0, it falls at the first edge at which both flags are clear. With `pwdn_i`=0, a powered-down loop returns to active at the next edge.
- R7: While a loop is powered down, `div_rst_o` is 1, both pump outputs are 0, and divider pulses set no flag.
- R8: `osc_en_o` is 0 only when both loops are powered down.
- R9: The mode fields are written {high bit, low bit}. When both high bits (`mode_main_i[1]`, `mode_aux_i[1]`) are 0, the low bits {main, aux} select the output: 00 gives constant 0, 01 the aux lock level, 10 the main lock level, 11 the AND of both lock levels.
- R10: When exactly one high bit is 1, that loop's divider pulse is passed to `fo_o`: its reference pulse if `mode_aux_i[0]`=0, its feedback pulse if `mode_aux_i[0]`=1.
- R11: When both high bits are 1 and both low bits are 0, `fo_o` equals the main loop's `x4_o`. This is the fast-lock switch.
- R12: When both high bits are 1, low bits {main, aux} of 01 reset the aux loop, 10 reset the main loop, and 11 reset both. A loop in reset has `div_rst_o`=1, flags cleared and pumps at 0, and `fo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 2 | Reference divider pulse per loop (bit 1 main, bit 0 aux) |
| fb_pulse_i | input | 2 | Feedback divider pulse per loop |
| pol_i | input | 2 | Pump polarity per loop |
| tri_i | input | 2 | Pump tri-state per loop |
| x4_cfg_i | input | 2 | Requested 4x current per loop |
| pwdn_i | input | 2 | Power-down request per loop |
| mode_main_i | input | 2 | Main mode field {high, low} |
| mode_aux_i | input | 2 | Aux mode field {high, low} |
| pump_up_o | output | 2 | Pump-up command per loop |
| pump_dn_o | output | 2 | Pump-down command per loop |
| x4_o | output | 2 | Applied 4x current flag per loop |
| lock_o | output | 2 | Lock level per loop |
| div_rst_o | output | 2 | Divider reset per loop |
| active_o | output | 2 | Loop powered and enabled |
| osc_en_o | output | 1 | Reference oscillator enable |
| fo_o | output | 1 | Multifunction output |

## Verification
The assertions assume that divider pulses and configuration inputs change only away from the clock edge and stay stable for a whole cycle. They also assume that a power-down request without tri-state can wait indefinitely while a single flag stays set. The stimulus changes every input at the falling edge. A reference model in the bench, built from the requirements, tracks the flags, power state and current flag of each loop and predicts every output. The sweeps cover all 4-cycle pulse patterns, all sixteen mode codes, and power-down requests issued at several offsets inside a pump pulse.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int unsigned N_LOOP = 2;
  localparam int unsigned AUX    = 0;
  localparam int unsigned MAIN   = 1;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned HI     = MODE_W - 1;
  localparam int unsigned LO     = 0;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ref_i,
  input  logic fb_i,
  input  logic pol_i,
  input  logic mute_i,
  output logic up_o,
  output logic dn_o,
  output logic busy_o
);
  logic ref_q, fb_q, both;

  assign both = ref_q & fb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else if (clr_i || both) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_q | ref_i;
      fb_q  <= fb_q | fb_i;
    end
  end

  assign up_o   = ~mute_i & (pol_i ? ref_q : fb_q);
  assign dn_o   = ~mute_i & (pol_i ? fb_q : ref_q);
  assign busy_o = ref_q | fb_q;

  // R2
  overlap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    both |=> !busy_o);
  // R7
  held_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !busy_o);
endmodule

// File: rtl/pfd_pwr.sv
module pfd_pwr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwdn_i,
  input  logic tri_i,
  input  logic busy_i,
  input  logic x4_cfg_i,
  output logic off_o,
  output logic x4_o,
  output logic lock_o
);
  logic off_q, x4_q, off_d;

  // without tri-state, power down is gated by the end of the pump pulse
  assign off_d = off_q ? pwdn_i : (pwdn_i & (tri_i | ~busy_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= 1'b0;
      x4_q  <= 1'b0;
    end else begin
      off_q <= off_d;
      if (!busy_i) x4_q <= x4_cfg_i;
    end
  end

  assign off_o  = off_q;
  assign x4_o   = x4_q;
  assign lock_o = off_q | ~busy_i;

  // R6
  gated_pwdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_q && pwdn_i && !tri_i && busy_i) |=> !off_q);
  // R6
  fast_pwdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!off_q && pwdn_i && tri_i) |=> off_q);
  // R5
  x4_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(x4_q));
endmodule

// File: rtl/pfd_fo_mux.sv
module pfd_fo_mux
  import pfd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_main_i,
  input  logic [MODE_W-1:0] mode_aux_i,
  input  logic [N_LOOP-1:0] lock_i,
  input  logic [N_LOOP-1:0] ref_i,
  input  logic [N_LOOP-1:0] fb_i,
  input  logic              fast_i,
  output logic              fo_o,
  output logic [N_LOOP-1:0] crst_o
);
  logic [1:0] hi, lo;

  assign hi = {mode_main_i[HI], mode_aux_i[HI]};
  assign lo = {mode_main_i[LO], mode_aux_i[LO]};

  always_comb begin
    fo_o   = 1'b0;
    crst_o = '0;
    unique case (hi)
      2'b00: begin
        unique case (lo)
          2'b00: fo_o = 1'b0;
          2'b01: fo_o = lock_i[AUX];
          2'b10: fo_o = lock_i[MAIN];
          default: fo_o = lock_i[AUX] & lock_i[MAIN];
        endcase
      end
      2'b01: fo_o = mode_aux_i[LO] ? fb_i[AUX] : ref_i[AUX];
      2'b10: fo_o = mode_aux_i[LO] ? fb_i[MAIN] : ref_i[MAIN];
      default: begin
        if (lo == 2'b00) fo_o = fast_i;
        else crst_o = lo;
      end
    endcase
  end
endmodule

// File: rtl/pfd_dual.sv
module pfd_dual
  import pfd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LOOP-1:0] ref_pulse_i,
  input  logic [N_LOOP-1:0] fb_pulse_i,
  input  logic [N_LOOP-1:0] pol_i,
  input  logic [N_LOOP-1:0] tri_i,
  input  logic [N_LOOP-1:0] x4_cfg_i,
  input  logic [N_LOOP-1:0] pwdn_i,
  input  logic [MODE_W-1:0] mode_main_i,
  input  logic [MODE_W-1:0] mode_aux_i,
  output logic [N_LOOP-1:0] pump_up_o,
  output logic [N_LOOP-1:0] pump_dn_o,
  output logic [N_LOOP-1:0] x4_o,
  output logic [N_LOOP-1:0] lock_o,
  output logic [N_LOOP-1:0] div_rst_o,
  output logic [N_LOOP-1:0] active_o,
  output logic              osc_en_o,
  output logic              fo_o
);
  logic [N_LOOP-1:0] busy, off, crst;

  for (genvar g = 0; g < N_LOOP; g++) begin : g_loop
    logic clr, mute;
    assign clr  = off[g] | crst[g];
    assign mute = clr | tri_i[g];

    pfd_core u_core (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .ref_i  (ref_pulse_i[g]),
      .fb_i   (fb_pulse_i[g]),
      .pol_i  (pol_i[g]),
      .mute_i (mute),
      .up_o   (pump_up_o[g]),
      .dn_o   (pump_dn_o[g]),
      .busy_o (busy[g])
    );

    pfd_pwr u_pwr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pwdn_i   (pwdn_i[g]),
      .tri_i    (tri_i[g]),
      .busy_i   (busy[g]),
      .x4_cfg_i (x4_cfg_i[g]),
      .off_o    (off[g]),
      .x4_o     (x4_o[g]),
      .lock_o   (lock_o[g])
    );

    assign div_rst_o[g] = clr;
    assign active_o[g]  = ~off[g];

    // R3
    tri_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tri_i[g] |-> !(pump_up_o[g] || pump_dn_o[g]));
    // R12
    rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_rst_o[g] |-> !(pump_up_o[g] || pump_dn_o[g]));
    // R4
    off_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !active_o[g] |-> lock_o[g]);
  end

  pfd_fo_mux u_mux (
    .mode_main_i (mode_main_i),
    .mode_aux_i  (mode_aux_i),
    .lock_i      (lock_o),
    .ref_i       (ref_pulse_i),
    .fb_i        (fb_pulse_i),
    .fast_i      (x4_o[MAIN]),
    .fo_o        (fo_o),
    .crst_o      (crst)
  );

  assign osc_en_o = ~&off;

  // R8
  osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (active_o == '0));
endmodule

// File: tb/sim_pfd_dual.sv
`timescale 1ns/1ps
module sim_pfd_dual;
  logic clk = 1'b0;
  logic rst_ni;
  logic [1:0] ref_p, fb_p, pol, tri_s, x4c, pwdn, mm, ma;
  logic [1:0] up, dn, x4, lock, drst, act;
  logic osc, fo;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  bit m_ref[2], m_fb[2], m_off[2], m_x4[2];

  always #2.5 clk = ~clk;

  pfd_dual u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
    .pol_i(pol), .tri_i(tri_s), .x4_cfg_i(x4c), .pwdn_i(pwdn),
    .mode_main_i(mm), .mode_aux_i(ma), .pump_up_o(up), .pump_dn_o(dn),
    .x4_o(x4), .lock_o(lock), .div_rst_o(drst), .active_o(act),
    .osc_en_o(osc), .fo_o(fo)
  );

  task automatic chk(input bit got, input bit exp, input string req, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic bit crst_of(input int l);
    if (mm[1] && ma[1] && {mm[0], ma[0]} != 2'b00)
      return (l == 1) ? mm[0] : ma[0];
    return 1'b0;
  endfunction

  function automatic bit mlock(input int l);
    return m_off[l] | ~(m_ref[l] | m_fb[l]);
  endfunction

  task automatic model_edge();
    for (int l = 0; l < 2; l++) begin
      bit busy, noff, clr;
      busy = m_ref[l] | m_fb[l];
      noff = m_off[l] ? pwdn[l] : (pwdn[l] & (tri_s[l] | ~busy));
      clr  = m_off[l] | crst_of(l);
      if (clr || (m_ref[l] && m_fb[l])) begin
        m_ref[l] = 1'b0; m_fb[l] = 1'b0;
      end else begin
        m_ref[l] = m_ref[l] | ref_p[l];
        m_fb[l]  = m_fb[l] | fb_p[l];
      end
      if (!busy) m_x4[l] = x4c[l];
      m_off[l] = noff;
    end
  endtask

  task automatic compare_all();
    bit efo;
    string tfo;
    for (int l = 0; l < 2; l++) begin
      bit cr, mute;
      string tp;
      cr   = crst_of(l);
      mute = tri_s[l] | m_off[l] | cr;
      if (tri_s[l]) tp = "R3";
      else if (m_off[l]) tp = "R7";
      else if (cr) tp = "R12";
      else if (m_ref[l] && m_fb[l]) tp = "R2";
      else tp = "R1";
      chk(up[l], ~mute & (pol[l] ? m_ref[l] : m_fb[l]), tp, $sformatf("up[%0d]", l));
      chk(dn[l], ~mute & (pol[l] ? m_fb[l] : m_ref[l]), tp, $sformatf("dn[%0d]", l));
      chk(lock[l], mlock(l), "R4", $sformatf("lock[%0d]", l));
      chk(x4[l], m_x4[l], "R5", $sformatf("x4[%0d]", l));
      chk(act[l], ~m_off[l], "R6", $sformatf("active[%0d]", l));
      chk(drst[l], m_off[l] | cr, cr ? "R12" : "R7", $sformatf("div_rst[%0d]", l));
    end
    chk(osc, ~(m_off[0] & m_off[1]), "R8", "osc_en");
    case ({mm[1], ma[1]})
      2'b00: begin
        tfo = "R9";
        case ({mm[0], ma[0]})
          2'b00: efo = 1'b0;
          2'b01: efo = mlock(0);
          2'b10: efo = mlock(1);
          default: efo = mlock(0) & mlock(1);
        endcase
      end
      2'b01: begin tfo = "R10"; efo = ma[0] ? fb_p[0] : ref_p[0]; end
      2'b10: begin tfo = "R10"; efo = ma[0] ? fb_p[1] : ref_p[1]; end
      default: begin
        if ({mm[0], ma[0]} == 2'b00) begin tfo = "R11"; efo = m_x4[1]; end
        else begin tfo = "R12"; efo = 1'b0; end
      end
    endcase
    chk(fo, efo, tfo, "fo");
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ref_p = '0; fb_p = '0;
  endtask

  initial begin
    rst_ni = 1'b1;
    ref_p = '0; fb_p = '0; pol = '0; tri_s = '0; x4c = '0; pwdn = '0; mm = '0; ma = '0;
    for (int l = 0; l < 2; l++) begin m_ref[l] = 0; m_fb[l] = 0; m_off[l] = 0; m_x4[l] = 0; end
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // reset state: R4 R5 R6 R8
    compare_all();
    @(negedge clk);
    rst_ni = 1'b1;

    // pulse pattern sweep: R1 R2 R3 R5
    for (int c = 0; c < 8; c++) begin
      pol   = {c[0], ~c[0]};
      tri_s = {c[1], c[1] & c[0]};
      for (int pr = 0; pr < 16; pr++) begin
        for (int pf = 0; pf < 16; pf++) begin
          for (int t = 0; t < 4; t++) begin
            ref_p = {pr[t], pf[t]};
            fb_p  = {pf[t], pr[t]};
            x4c   = {pr[t] ^ c[2], pf[t]};
            cyc();
          end
          idle_inputs();
          cyc(); cyc();
        end
      end
    end
    tri_s = '0;
    // clear any leftover single flag
    ref_p = 2'b11; fb_p = 2'b11; cyc(); idle_inputs(); cyc(); cyc();

    // power-down sequencing: R6 R7 R8
    for (int tr = 0; tr < 2; tr++) begin
      for (int which = 1; which < 4; which++) begin
        for (int d = 0; d < 4; d++) begin
          tri_s = {tr[0], tr[0]};
          ref_p = 2'b11; cyc(); idle_inputs();
          for (int k = 0; k < 6; k++) begin
            if (k == d) pwdn = which[1:0];
            if (k == 3) fb_p = 2'b11;
            if (k == 4) ref_p = 2'b11;
            cyc();
            idle_inputs();
          end
          pwdn = '0;
          cyc(); cyc();
          fb_p = 2'b11; cyc(); idle_inputs(); cyc(); cyc();
        end
      end
    end
    tri_s = '0;
    ref_p = 2'b11; fb_p = 2'b11; cyc(); idle_inputs(); cyc(); cyc();

    // multifunction selector sweep: R9 R10 R11 R12
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int p = 0; p < 16; p++) begin
          mm = a[1:0]; ma = b[1:0];
          x4c = {p[3], p[2]};
          ref_p = p[1:0]; fb_p = {p[0], p[2]};
          cyc();
          ref_p = {p[3], p[1]}; fb_p = p[1:0];
          cyc();
          idle_inputs();
          cyc();
          ref_p = 2'b11; fb_p = 2'b11; cyc(); idle_inputs(); cyc();
        end
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule